// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table that sits in ordinary memory. A client presents a request made of a virtual address and an access kind (read, write or instruction fetch). The walker then issues one word read per table level on a simple synchronous memory read port. It answers with either a physical page number plus that page's permission bits, or a two-bit fault code.

Software selects the active table set by writing the physical page of the top-level table into a root register. Changing that register moves the walker to another process's tables. The walker copies the root value when it accepts a request, so a write to the root during a walk only affects later walks.

The walk ends after the first read if the top-level entry is not valid. It reports three faults separately: a missing second-level table, a page that is not resident, and an access the page does not permit.

Top module: `ptw_walker`

## Requirements
- R1: While reset is low and in the first cycle after it, `req_ready` is 1, and `done`, `mem_rd_en`, `fault`, `rights`, `ppn` and `paddr` are 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. In the next cycle `mem_rd_en` is 1 and `mem_rd_addr` equals (root page << 12) + 4 × vaddr[31:22].
- R3: If the first-level entry is valid, the second read goes to (entry[19:0] << 12) + 4 × vaddr[21:12]. A full walk makes exactly two reads, and `done` is high during the cycle that follows the fourth rising edge after the accepting edge (memory answers one cycle after each read).
- R4: A first-level entry with bit 31 = 0 gives fault code 01. The walk makes exactly one read, and `done` is high during the cycle that follows the second rising edge after the accepting edge.
- R5: A second-level entry with bit 31 = 0 gives fault code 10, whatever its other bits hold.
- R6: Second-level entry bits 30, 29 and 28 grant read, write and fetch. Access kind 00 (read) needs bit 30, 01 (write) needs bit 29, 10 (fetch) needs bit 28, and 11 is never granted. A valid entry that lacks the needed bit gives fault code 11.
- R7: On success the fault code is 00, `ppn` is entry[19:0], `rights` is entry[30:28] (bit 2 = read, bit 1 = write, bit 0 = fetch), and `paddr` is {entry[19:0], vaddr[11:0]}.
- R8: On any fault, `ppn`, `rights` and `paddr` are 0.
- R9: `done` lasts exactly one cycle. The result outputs change only in that cycle and hold their values until the next `done`.
- R10: `req_ready` is 1 only when the walker is idle, so a request raised during a walk is ignored: it triggers no memory read and the walker does not start a walk for it. `req_ready` is 1 again in the cycle after `done`.
- R11: A walk uses the root value held before its accepting edge. A root write made in the same cycle as the accepting edge, or later during the walk, affects only later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_we | input | 1 | Write strobe for the root table page register |
| root_wdata | input | 20 | New physical page of the first-level table |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| req_ready | output | 1 | Walker idle and able to accept a request |
| mem_rd_en | output | 1 | Table word read request |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rd_valid | input | 1 | Read data strobe from memory |
| mem_rd_data | input | 32 | Table entry returned by memory |
| done | output | 1 | One-cycle result strobe |
| fault | output | 2 | 00 none, 01 no second-level table, 10 page absent, 11 access denied |
| ppn | output | 20 | Translated physical page number |
| rights | output | 3 | Page permissions {read, write, fetch} |
| paddr | output | 32 | Translated physical byte address |

## Verification
The bench targets the boundaries that wrong index arithmetic would break. The top index and top offset (all ones) would expose a wrong shift or a truncated sum, because either one lands on a wrong table word. An invalid first-level entry must end the walk after one read. A walker that skipped this check would read a garbage second-level table and return fault 10 or even a translation. A non-valid second-level entry with rights and page bits set must still give fault 10 with zeroed outputs, which catches a design that tests permissions before validity. Every access kind runs against pages with partial rights, including the reserved kind. Root writes made on the accepting edge and during the walk catch a walker that reads the live register instead of its copy. A request pulsed mid-walk must cause no extra read.

// File: rtl/ptw_pkg.sv
// Package: shared sizes, field positions and encodings of the table walker.
// Assumes 32-bit entries and a byte-addressed memory returning whole words.
package ptw_pkg;
    localparam int VA_W    = 32;
    localparam int IDX_W   = 10;
    localparam int OFF_W   = 12;
    localparam int PPN_W   = 20;
    localparam int PTE_W   = 32;
    localparam int LEVELS  = 2;
    localparam int ENT_LG2 = 2;

    localparam int PTE_V_BIT = 31;
    localparam int PTE_R_BIT = 30;
    localparam int PTE_X_BIT = 28;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_READ, ST_L1_WAIT, ST_L2_READ, ST_L2_WAIT, ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_DIR  = 2'b01,
        FLT_PAGE = 2'b10,
        FLT_PERM = 2'b11
    } fault_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_t;
endpackage

// File: rtl/ptw_root_reg.sv
// Module: root table page register.
// Holds the physical page of the first-level table; software rewrites it
// to change address space. Assumes writes may arrive in any cycle.
module ptw_root_reg #(
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [PPN_W-1:0] wdata_i,
    output logic [PPN_W-1:0] root_o
);
    // Capture a software write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    root_o <= '0;
        else if (we_i) root_o <= wdata_i;
    end
endmodule

// File: rtl/ptw_entry_addr.sv
// Module: entry address generator for one table level.
// Forms the table page base shifted to a byte address plus the index scaled
// by the entry size. Assumes tables are page aligned.
module ptw_entry_addr #(
    parameter int PPN_W   = 20,
    parameter int IDX_W   = 10,
    parameter int OFF_W   = 12,
    parameter int ENT_LG2 = 2,
    localparam int ADDR_W = PPN_W + OFF_W
) (
    input  logic [PPN_W-1:0]  tbl_ppn_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] page_base;
    logic [ADDR_W-1:0] slot_off;

    // Scale page number and index into byte quantities and sum them.
    always_comb begin
        page_base = {tbl_ppn_i, {OFF_W{1'b0}}};
        slot_off  = ADDR_W'({idx_i, {ENT_LG2{1'b0}}});
        addr_o    = page_base + slot_off;
    end
endmodule

// File: rtl/ptw_perm_check.sv
// Module: permission check for a resident page.
// Rights are {read, write, fetch}; the reserved access kind is never granted.
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [1:0] kind_i,
    input  logic [2:0] rights_i,
    output logic       allow_o
);
    // Select the one rights bit that the access kind needs.
    always_comb begin
        unique case (acc_t'(kind_i))
            ACC_READ:  allow_o = rights_i[2];
            ACC_WRITE: allow_o = rights_i[1];
            ACC_FETCH: allow_o = rights_i[0];
            default:   allow_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
// Module: two-level table walker (top).
// Accepts one request when idle, reads the first-level entry, stops with a
// fault if it is not valid, otherwise reads the second-level entry, checks
// validity then rights, and posts a registered result with a one-cycle done.
// Assumes a memory that answers each read with mem_rd_valid after one or
// more cycles and never answers unasked.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int P_VA_W  = VA_W,
    parameter int P_IDX_W = IDX_W,
    parameter int P_OFF_W = OFF_W,
    parameter int P_PPN_W = PPN_W,
    parameter int P_PTE_W = PTE_W,
    localparam int MA_W   = P_PPN_W + P_OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               root_we,
    input  logic [P_PPN_W-1:0] root_wdata,
    input  logic               req_valid,
    input  logic [P_VA_W-1:0]  req_vaddr,
    input  logic [1:0]         req_kind,
    output logic               req_ready,
    output logic               mem_rd_en,
    output logic [MA_W-1:0]    mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [P_PTE_W-1:0] mem_rd_data,
    output logic               done,
    output logic [1:0]         fault,
    output logic [P_PPN_W-1:0] ppn,
    output logic [2:0]         rights,
    output logic [MA_W-1:0]    paddr
);
    walk_state_t        state_q;
    logic [P_VA_W-1:0]  va_q;
    logic [1:0]         kind_q;
    logic [P_PPN_W-1:0] tbl_ppn_q;
    logic [P_PPN_W-1:0] root_q;
    logic [MA_W-1:0]    lvl_addr [LEVELS];
    logic               allow;
    logic               ent_valid;
    logic [2:0]         ent_rights;
    logic [P_PPN_W-1:0] ent_ppn;
    logic               unused_pte_bits;

    ptw_root_reg #(.PPN_W(P_PPN_W)) u_root (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (root_we),
        .wdata_i (root_wdata),
        .root_o  (root_q)
    );

    // One address generator per level, each on its own index slice.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        ptw_entry_addr #(
            .PPN_W(P_PPN_W), .IDX_W(P_IDX_W), .OFF_W(P_OFF_W), .ENT_LG2(ENT_LG2)
        ) u_addr (
            .tbl_ppn_i (tbl_ppn_q),
            .idx_i     (va_q[P_VA_W-1-g*P_IDX_W -: P_IDX_W]),
            .addr_o    (lvl_addr[g])
        );
    end

    // Split the returned entry into its fields.
    always_comb begin
        ent_valid  = mem_rd_data[PTE_V_BIT];
        ent_rights = mem_rd_data[PTE_R_BIT:PTE_X_BIT];
        ent_ppn    = mem_rd_data[P_PPN_W-1:0];
    end
    assign unused_pte_bits = ^mem_rd_data[PTE_X_BIT-1:P_PPN_W];

    ptw_perm_check u_perm (
        .kind_i   (kind_q),
        .rights_i (ent_rights),
        .allow_o  (allow)
    );

    // Handshake and memory port driven from the walk state.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        done        = (state_q == ST_DONE);
        mem_rd_en   = (state_q == ST_L1_READ) || (state_q == ST_L2_READ);
        mem_rd_addr = (state_q == ST_L2_READ) ? lvl_addr[1] : lvl_addr[0];
    end

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            va_q      <= '0;
            kind_q    <= '0;
            tbl_ppn_q <= '0;
            fault     <= FLT_NONE;
            ppn       <= '0;
            rights    <= '0;
            paddr     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q      <= req_vaddr;
                        kind_q    <= req_kind;
                        tbl_ppn_q <= root_q;
                        state_q   <= ST_L1_READ;
                    end
                end
                ST_L1_READ: state_q <= ST_L1_WAIT;
                ST_L1_WAIT: begin
                    if (mem_rd_valid) begin
                        if (!ent_valid) begin
                            fault   <= FLT_DIR;
                            ppn     <= '0;
                            rights  <= '0;
                            paddr   <= '0;
                            state_q <= ST_DONE;
                        end else begin
                            tbl_ppn_q <= ent_ppn;
                            state_q   <= ST_L2_READ;
                        end
                    end
                end
                ST_L2_READ: state_q <= ST_L2_WAIT;
                ST_L2_WAIT: begin
                    if (mem_rd_valid) begin
                        state_q <= ST_DONE;
                        if (!ent_valid || !allow) begin
                            fault  <= !ent_valid ? FLT_PAGE : FLT_PERM;
                            ppn    <= '0;
                            rights <= '0;
                            paddr  <= '0;
                        end else begin
                            fault  <= FLT_NONE;
                            ppn    <= ent_ppn;
                            rights <= ent_rights;
                            paddr  <= {ent_ppn, va_q[P_OFF_W-1:0]};
                        end
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
// Module: protocol checker for the table walker, attached with bind.
// Counts memory reads per walk to check how many levels were visited.
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_rd_en,
    input logic        done,
    input logic [1:0]  fault,
    input logic [2:0]  rights,
    input logic [19:0] ppn,
    input logic [31:0] paddr
);
    logic [1:0] rd_cnt;

    // Reads issued since the last accepted request (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)                     rd_cnt <= '0;
        else if (req_valid && req_ready) rd_cnt <= '0;
        else if (mem_rd_en && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !done && !mem_rd_en));

    a_r2_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_rd_en);

    a_r3_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 2'b01) |-> rd_cnt == 2'd2);

    a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault == 2'b01) |-> rd_cnt == 2'd1);

    a_r8_fault_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 2'b00) |-> (paddr == '0 && ppn == '0 && rights == '0));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(paddr) || !$stable(fault) || !$stable(rights)) |-> done);

    a_r10_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_rd_en (mem_rd_en),
    .done      (done),
    .fault     (fault),
    .rights    (rights),
    .ppn       (ppn),
    .paddr     (paddr)
);

// File: tb/tb_ptw_walker.sv
// Bench: behavioural memory and walk model, compared with the walker every cycle.
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_we = 1'b0;
    logic [19:0] root_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_ready;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        done;
    logic [1:0]  fault;
    logic [19:0] ppn;
    logic [2:0]  rights;
    logic [31:0] paddr;

    int n_chk = 0;
    int n_fail = 0;
    logic [19:0] cur_root = '0;
    logic [31:0] mem [int unsigned];
    int unsigned rd_log [$];

    always #2 clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .req_ready(req_ready), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .done(done),
        .fault(fault), .ppn(ppn), .rights(rights), .paddr(paddr)
    );

    function automatic logic [31:0] rdm(input int unsigned a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory model: one-cycle read latency, logs every read address.
    always @(posedge clk) begin
        mem_rd_valid <= mem_rd_en;
        if (mem_rd_en) begin
            mem_rd_data <= rdm(mem_rd_addr);
            rd_log.push_back(mem_rd_addr);
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_va(input int i1, input int i2, input int off);
        return {i1[9:0], i2[9:0], off[11:0]};
    endfunction

    // wr_mode: 0 none, 1 root write on the accepting edge, 2 root write mid-walk.
    task automatic run_walk(input logic [31:0] va, input logic [1:0] kind,
                            input int wr_mode, input logic [19:0] new_root,
                            input bit poke);
        int unsigned l1a, l2a;
        logic [31:0] e1, e2;
        logic [1:0]  xf;
        logic [19:0] xppn;
        logic [2:0]  xr;
        logic [31:0] xpa;
        int lat, nrd;
        bit ok;
        logic [31:0] hold_pa;
        logic [1:0]  hold_f;
        l1a = {cur_root, 12'h0} + va[31:22] * 4;
        e1 = rdm(l1a);
        l2a = {e1[19:0], 12'h0} + va[21:12] * 4;
        e2 = rdm(l2a);
        xppn = '0; xr = '0; xpa = '0;
        if (!e1[31]) begin
            xf = 2'b01; lat = 2; nrd = 1;
        end else begin
            lat = 4; nrd = 2;
            case (kind)
                2'b00: ok = e2[30];
                2'b01: ok = e2[29];
                2'b10: ok = e2[28];
                default: ok = 1'b0;
            endcase
            if (!e2[31]) xf = 2'b10;
            else if (!ok) xf = 2'b11;
            else begin
                xf = 2'b00; xppn = e2[19:0]; xr = e2[30:28]; xpa = {e2[19:0], va[11:0]};
            end
        end
        @(negedge clk);
        chk(req_ready === 1'b1, "R10 ready while idle", 32'(req_ready), 32'd1);
        rd_log.delete();
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        if (wr_mode == 1) begin root_we = 1'b1; root_wdata = new_root; end
        @(negedge clk);
        req_valid = 1'b0; root_we = 1'b0;
        if (wr_mode == 1) cur_root = new_root;
        chk(req_ready === 1'b0, "R10 busy after accept", 32'(req_ready), 32'd0);
        chk(mem_rd_en === 1'b1 && mem_rd_addr === l1a, "R2 first-level read address",
            mem_rd_addr, l1a);
        if (poke) begin req_valid = 1'b1; req_vaddr = ~va; req_kind = 2'b00; end
        if (wr_mode == 2) begin root_we = 1'b1; root_wdata = new_root; end
        for (int n = 1; n <= lat; n++) begin
            @(negedge clk);
            req_valid = 1'b0; root_we = 1'b0;
            if (n == 1 && wr_mode == 2) cur_root = new_root;
            chk(done === (n == lat), "R9 done cycle", 32'(done), 32'(n == lat));
        end
        chk(fault === xf, "R4 R5 R6 fault code", 32'(fault), 32'(xf));
        chk(ppn === xppn && rights === xr, "R7 R8 page and rights",
            {9'h0, rights, ppn}, {9'h0, xr, xppn});
        chk(paddr === xpa, "R7 R8 physical address", paddr, xpa);
        chk(rd_log.size() == nrd, "R3 R4 read count", rd_log.size(), nrd);
        if (nrd == 2 && rd_log.size() == 2)
            chk(rd_log[1] == l2a, "R3 second-level read address", rd_log[1], l2a);
        hold_pa = paddr; hold_f = fault;
        @(negedge clk);
        chk(done === 1'b0 && req_ready === 1'b1, "R9 R10 done ends, ready returns",
            {30'h0, done, req_ready}, 32'd1);
        chk(paddr === hold_pa && fault === hold_f, "R9 result held", paddr, hold_pa);
        @(negedge clk);
        chk(rd_log.size() == nrd && mem_rd_en === 1'b0, "R10 ignored request made no read",
            rd_log.size(), nrd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Tables for root page 0x00010.
        mem[32'h0001_000C] = 32'h8000_0020;              // L1[3] -> table 0x20
        mem[32'h0002_0014] = 32'hE000_0000 | 32'h12345;  // L2[5]: r w, valid
        mem[32'h0002_0018] = 32'h7000_1111;              // L2[6]: not valid, bits set
        mem[32'h0002_0024] = 32'h9000_0777;              // L2[9]: fetch only
        mem[32'h0002_0028] = 32'hF000_0555;              // L2[10]: all rights
        mem[32'h0001_0FFC] = 32'h8000_0050;              // L1[1023] -> table 0x50
        mem[32'h0005_0FFC] = 32'hC00F_FFFF;              // L2[1023]: read, ppn all ones
        // Tables for root page 0x00030.
        mem[32'h0003_000C] = 32'h8000_0040;
        mem[32'h0004_0014] = 32'hC000_0000 | 32'hABCDE;  // read only

        repeat (4) @(negedge clk);
        chk(req_ready === 1'b1 && done === 1'b0 && mem_rd_en === 1'b0, "R1 reset outputs",
            {29'h0, req_ready, done, mem_rd_en}, 32'd4);
        chk(fault === 2'b00 && paddr === 32'h0 && ppn === 20'h0 && rights === 3'h0,
            "R1 reset results", paddr, 32'h0);
        root_we = 1'b1; root_wdata = 20'h00010; cur_root = 20'h00010;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        root_we = 1'b0;
        chk(req_ready === 1'b1 && done === 1'b0, "R1 first cycle after reset",
            32'(req_ready), 32'd1);
        cur_root = 20'h00010;

        run_walk(mk_va(3, 5, 12'hABC), 2'b00, 0, '0, 0); // R7 read success
        run_walk(mk_va(3, 5, 12'h123), 2'b01, 0, '0, 1); // R7 write, R10 poke
        run_walk(mk_va(3, 5, 12'h000), 2'b10, 0, '0, 0); // R6 fetch denied
        run_walk(mk_va(3, 5, 12'h000), 2'b11, 0, '0, 0); // R6 reserved kind
        run_walk(mk_va(3, 9, 12'h444), 2'b10, 0, '0, 0); // R6 fetch allowed
        run_walk(mk_va(3, 9, 12'h444), 2'b00, 0, '0, 0); // R6 read denied
        run_walk(mk_va(3, 10, 12'h010), 2'b11, 0, '0, 0); // R6 reserved, all rights
        run_walk(mk_va(3, 6, 12'h010), 2'b00, 0, '0, 0); // R5 not present
        run_walk(mk_va(7, 5, 12'h010), 2'b00, 0, '0, 1); // R4 first level invalid
        run_walk(mk_va(1023, 1023, 12'hFFF), 2'b00, 0, '0, 0); // R2 R3 top indices
        run_walk(mk_va(3, 5, 12'hABC), 2'b00, 1, 20'h00030, 0); // R11 write on accept
        run_walk(mk_va(3, 5, 12'hABC), 2'b00, 2, 20'h00010, 0); // R11 mid-walk, new root
        run_walk(mk_va(3, 5, 12'hABC), 2'b00, 0, '0, 0); // R11 back on root 0x10

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule